// File: doc/BRIEF.md
# Reset Source Arbiter

This block gathers every event that may reset the system and turns them into two reset levels. The heavier one, `por_o`, restarts the whole chip. The lighter one, `puc_o`, restarts only the CPU and the state that depends on it. The heavier level always carries the lighter one with it. Some sources raise only the lighter level.

Power-on reset has three triggers:
- loss of supply, which asserts it asynchronously;
- a low level on the external reset pin while the pin is in reset mode;
- the supply-supervisor low flag, but only while its reset-enable input is set.

Once every power-on source is inactive, the reset is held for a programmable number of clock cycles. This delay stands in for the settling time that follows brownout recovery.

The lighter reset has three triggers: any active power-on reset, a watchdog expiry in supervision mode, and a flash key violation. A strobe stretches it for a fixed number of cycles.

While a reset is active, the block presents the address of the reset vector. A sticky cause register records the source of the last reset. Software clears this register, and a power-on event replaces its contents.

Top module: `rst_arbiter`

## Requirements
- R1: While `supply_ok_i` is low, `por_o` and `puc_o` are high without waiting for a clock edge, and `cause_o` reads 5'b00001.
- R2: Power-on reset falls on the RELEASE_CYCLES-th rising edge at which all power-on sources are sampled inactive. For the pin, this sampling is at the output of its synchronizer. Any active source during the count restarts the count.
- R3: In reset mode (`pin_nmi_mode_i` = 0), a low on `rst_pin_n_i` passes through a two-stage synchronizer. `por_o` and `puc_o` rise after the third rising edge that follows the falling pin, and `cause_o` then reads 5'b00010.
- R4: In NMI mode (`pin_nmi_mode_i` = 1), a low on the pin raises neither reset and leaves `cause_o` unchanged.
- R5: When `svs_low_i` and `svs_por_en_i` are both high at a rising edge, `por_o` is high after that edge and `cause_o` reads 5'b00100. When `svs_por_en_i` is low, `svs_low_i` has no effect.
- R6: Whenever `por_o` is high, `puc_o` is high.
- R7: A one-cycle `wdt_expire_i` in supervision mode (`wdt_interval_mode_i` = 0) raises `puc_o` for PUC_CYCLES cycles after the next edge, without raising `por_o`, and sets `cause_o` bit 3. In interval mode the strobe is ignored.
- R8: A one-cycle `flash_key_viol_i` raises `puc_o` for PUC_CYCLES cycles after the next edge and sets `cause_o` bit 4.
- R9: While `puc_o` is high, `reset_vector_o` equals VEC_ADDR (default 16'hFFFE). Otherwise it reads zero.
- R10: Each cause bit has a fixed meaning: bit 0 supply, bit 1 pin, bit 2 supervisor, bit 3 watchdog, bit 4 flash. Watchdog and flash bits accumulate onto the current contents. A pin or supervisor event replaces the whole register with its own bit.
- R11: A high `cause_clear_i` at a rising edge clears `cause_o` to zero, unless an event at that edge sets bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| supply_ok_i | input | 1 | Power-good indication; low means brownout, asynchronous |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| pin_nmi_mode_i | input | 1 | 1 selects NMI function for the pin (no reset) |
| svs_low_i | input | 1 | Supply-supervisor low-voltage flag |
| svs_por_en_i | input | 1 | Lets the supervisor flag raise power-on reset |
| wdt_expire_i | input | 1 | Watchdog expiry strobe |
| wdt_interval_mode_i | input | 1 | 1 selects interval-timer mode (no reset) |
| flash_key_viol_i | input | 1 | Flash control key violation strobe |
| cause_clear_i | input | 1 | Software clear of the cause register |
| por_o | output | 1 | Power-on reset, active high |
| puc_o | output | 1 | Power-up-clear reset, active high |
| reset_vector_o | output | ADDR_W | Reset vector address while reset is active |
| cause_o | output | 5 | Sticky reset cause bits |

## Verification
Each result has its own latency:
- Loss of supply shows at the outputs at once, and it is checked a fraction of a nanosecond after the drive.
- Supervisor, watchdog and flash events appear one edge after they are sampled.
- The pin shows three edges after it falls.
- Release comes RELEASE_CYCLES edges after the last sampled source, and two more edges are added for the pin path.

The bench counts rising edges and drives inputs just after a falling edge. It queues each expected output with the edge number at which that output is due. The monitor compares only at the falling edge after that numbered rising edge, so each check lands on the first cycle where the new value is valid and also on the last cycle where the old value should still hold.

// File: rtl/rst_arb_pkg.sv
package rst_arb_pkg;

   localparam int CAUSE_W = 5;

   typedef enum int unsigned {
      SRC_SUPPLY = 0,
      SRC_PIN    = 1,
      SRC_SVS    = 2,
      SRC_WDT    = 3,
      SRC_FLASH  = 4
   } src_e;

   typedef logic [CAUSE_W-1:0] cause_t;

   function automatic cause_t src_bit(src_e s);
      cause_t c;
      c = '0;
      c[int'(s)] = 1'b1;
      return c;
   endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rst_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   // Pin reads as released while supply is absent, so it cannot stretch power-up.
   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         stage_q <= '1;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/por_release_timer.sv
module por_release_timer #(
   parameter int RELEASE_CYCLES = 16000
) (
   input  logic clk_i,
   input  logic pwr_ok_i,
   input  logic hold_i,
   output logic por_o
);

   if (RELEASE_CYCLES < 1) begin : g_bad_release
      $error("por_release_timer: RELEASE_CYCLES must be at least 1");
   end

   localparam int CNT_W = $clog2(RELEASE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             por_q;

   always_ff @(posedge clk_i or negedge pwr_ok_i) begin
      if (!pwr_ok_i) begin
         por_q <= 1'b1;
         cnt_q <= '0;
      end else if (hold_i) begin
         por_q <= 1'b1;
         cnt_q <= '0;
      end else if (por_q) begin
         if (cnt_q == LAST) begin
            por_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign por_o = por_q;

endmodule

// File: rtl/puc_stretcher.sv
module puc_stretcher #(
   parameter int PUC_CYCLES = 4
) (
   input  logic clk_i,
   input  logic pwr_ok_i,
   input  logic trig_i,
   input  logic por_i,
   output logic puc_o
);

   if (PUC_CYCLES < 1) begin : g_bad_puc
      $error("puc_stretcher: PUC_CYCLES must be at least 1");
   end

   logic active;

   if (PUC_CYCLES == 1) begin : g_single
      logic hit_q;
      always_ff @(posedge clk_i or negedge pwr_ok_i) begin
         if (!pwr_ok_i) hit_q <= 1'b0;
         else           hit_q <= trig_i;
      end
      assign active = hit_q;
   end else begin : g_count
      localparam int PW = $clog2(PUC_CYCLES + 1);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk_i or negedge pwr_ok_i) begin
         if (!pwr_ok_i) begin
            left_q <= '0;
         end else if (trig_i) begin
            left_q <= PW'(PUC_CYCLES);
         end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end
      end
      assign active = (left_q != '0);
   end

   assign puc_o = por_i | active;

endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
   import rst_arb_pkg::*;
(
   input  logic   clk_i,
   input  logic   pwr_ok_i,
   input  logic   pin_hit_i,
   input  logic   svs_hit_i,
   input  logic   wdt_hit_i,
   input  logic   flash_hit_i,
   input  logic   clear_i,
   output cause_t cause_o
);

   cause_t cause_q;
   cause_t por_bits;
   cause_t puc_bits;
   cause_t base;

   always_comb begin
      por_bits = '0;
      puc_bits = '0;
      if (pin_hit_i)   por_bits = por_bits | src_bit(SRC_PIN);
      if (svs_hit_i)   por_bits = por_bits | src_bit(SRC_SVS);
      if (wdt_hit_i)   puc_bits = puc_bits | src_bit(SRC_WDT);
      if (flash_hit_i) puc_bits = puc_bits | src_bit(SRC_FLASH);
      base = clear_i ? '0 : cause_q;
   end

   always_ff @(posedge clk_i or negedge pwr_ok_i) begin
      if (!pwr_ok_i) begin
         cause_q <= src_bit(SRC_SUPPLY);
      end else if (por_bits != '0) begin
         cause_q <= por_bits;
      end else begin
         cause_q <= base | puc_bits;
      end
   end

   assign cause_o = cause_q;

endmodule

// File: rtl/rst_arbiter.sv
module rst_arbiter
   import rst_arb_pkg::*;
#(
   parameter int                 ADDR_W         = 16,
   parameter logic [ADDR_W-1:0]  VEC_ADDR       = ADDR_W'('hFFFE),
   parameter int                 RELEASE_CYCLES = 16000,
   parameter int                 PUC_CYCLES     = 4,
   parameter int                 SYNC_STAGES    = 2
) (
   input  logic              clk_i,
   input  logic              supply_ok_i,
   input  logic              rst_pin_n_i,
   input  logic              pin_nmi_mode_i,
   input  logic              svs_low_i,
   input  logic              svs_por_en_i,
   input  logic              wdt_expire_i,
   input  logic              wdt_interval_mode_i,
   input  logic              flash_key_viol_i,
   input  logic              cause_clear_i,
   output logic              por_o,
   output logic              puc_o,
   output logic [ADDR_W-1:0] reset_vector_o,
   output logic [CAUSE_W-1:0] cause_o
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("rst_arbiter: ADDR_W must be positive");
   end

   logic pin_sync;
   logic pin_hit;
   logic svs_hit;
   logic por_hold;
   logic wdt_hit;
   logic flash_hit;
   logic puc_trig;
   logic por_int;
   logic puc_int;

   rst_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i    (clk_i),
      .arst_n_i (supply_ok_i),
      .d_i      (rst_pin_n_i),
      .q_o      (pin_sync)
   );

   assign pin_hit   = !pin_sync && !pin_nmi_mode_i;
   assign svs_hit   = svs_low_i && svs_por_en_i;
   assign por_hold  = pin_hit || svs_hit;
   assign wdt_hit   = wdt_expire_i && !wdt_interval_mode_i;
   assign flash_hit = flash_key_viol_i;
   assign puc_trig  = wdt_hit || flash_hit;

   por_release_timer #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_por_timer (
      .clk_i    (clk_i),
      .pwr_ok_i (supply_ok_i),
      .hold_i   (por_hold),
      .por_o    (por_int)
   );

   puc_stretcher #(.PUC_CYCLES(PUC_CYCLES)) u_puc (
      .clk_i    (clk_i),
      .pwr_ok_i (supply_ok_i),
      .trig_i   (puc_trig),
      .por_i    (por_int),
      .puc_o    (puc_int)
   );

   reset_cause_reg u_cause (
      .clk_i       (clk_i),
      .pwr_ok_i    (supply_ok_i),
      .pin_hit_i   (pin_hit),
      .svs_hit_i   (svs_hit),
      .wdt_hit_i   (wdt_hit),
      .flash_hit_i (flash_hit),
      .clear_i     (cause_clear_i),
      .cause_o     (cause_o)
   );

   assign por_o          = por_int;
   assign puc_o          = puc_int;
   assign reset_vector_o = puc_int ? VEC_ADDR : '0;

endmodule

// File: rtl/rst_arbiter_chk.sv
module rst_arbiter_chk #(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'('hFFFE)
) (
   input logic              clk_i,
   input logic              supply_ok_i,
   input logic              svs_low_i,
   input logic              svs_por_en_i,
   input logic              wdt_expire_i,
   input logic              wdt_interval_mode_i,
   input logic              flash_key_viol_i,
   input logic              por_o,
   input logic              puc_o,
   input logic [ADDR_W-1:0] reset_vector_o,
   input logic              cause_svs_i,
   input logic              cause_wdt_i,
   input logic              cause_flash_i
);

   AST_POR_FORCES_PUC: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      por_o |-> puc_o); // R6

   AST_VECTOR_IN_RESET: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      puc_o |-> (reset_vector_o == VEC_ADDR)); // R9

   AST_VECTOR_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      !puc_o |-> (reset_vector_o == '0)); // R9

   AST_SVS_RAISES_POR: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (svs_low_i && svs_por_en_i) |=> (por_o && cause_svs_i)); // R5

   AST_WDT_RAISES_PUC: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (wdt_expire_i && !wdt_interval_mode_i) |=> puc_o); // R7

   AST_FLASH_RAISES_PUC: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      flash_key_viol_i |=> puc_o); // R8

   AST_WDT_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (wdt_expire_i && !wdt_interval_mode_i && !por_o && !svs_low_i) |=> (cause_wdt_i || por_o)); // R10

   AST_FLASH_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (flash_key_viol_i && !por_o && !svs_low_i) |=> (cause_flash_i || por_o)); // R8

endmodule

bind rst_arbiter rst_arbiter_chk #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) i_chk (
   .clk_i               (clk_i),
   .supply_ok_i         (supply_ok_i),
   .svs_low_i           (svs_low_i),
   .svs_por_en_i        (svs_por_en_i),
   .wdt_expire_i        (wdt_expire_i),
   .wdt_interval_mode_i (wdt_interval_mode_i),
   .flash_key_viol_i    (flash_key_viol_i),
   .por_o               (por_o),
   .puc_o               (puc_o),
   .reset_vector_o      (reset_vector_o),
   .cause_svs_i         (cause_o[2]),
   .cause_wdt_i         (cause_o[3]),
   .cause_flash_i       (cause_o[4])
);

// File: tb/test_rst_arbiter.sv
`timescale 1ns/1ps
module test_rst_arbiter;

   localparam int RC = 12;
   localparam int PC = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic supply_ok = 1'b1;
   logic pin_n = 1'b1, nmi_mode = 1'b0, svs_low = 1'b0, svs_en = 1'b0;
   logic wdt = 1'b0, wmode = 1'b0, flash = 1'b0, clr = 1'b0;
   logic por, puc;
   logic [15:0] vec;
   logic [4:0]  cause;

   rst_arbiter #(.RELEASE_CYCLES(RC), .PUC_CYCLES(PC)) i_rst_arbiter (
      .clk_i (clk), .supply_ok_i (supply_ok), .rst_pin_n_i (pin_n),
      .pin_nmi_mode_i (nmi_mode), .svs_low_i (svs_low), .svs_por_en_i (svs_en),
      .wdt_expire_i (wdt), .wdt_interval_mode_i (wmode),
      .flash_key_viol_i (flash), .cause_clear_i (clr),
      .por_o (por), .puc_o (puc), .reset_vector_o (vec), .cause_o (cause)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int compared = 0, mismatched = 0;
   bit done = 1'b0;

   int         due_q[$];
   logic [6:0] val_q[$];
   string      req_q[$];

   task automatic check(string req, logic p, logic u, logic [4:0] c);
      logic [15:0] ev;
      ev = u ? 16'hFFFE : 16'h0000;
      compared++;
      if (por !== p || puc !== u || cause !== c || vec !== ev) begin
         mismatched++;
         $display("FAIL %s (vector R9) cyc %0d: got por=%b puc=%b cause=%b vec=%h expected por=%b puc=%b cause=%b vec=%h",
                  req, cyc, por, puc, cause, vec, p, u, c, ev);
      end
   endtask

   task automatic expect_at(int ofs, logic p, logic u, logic [4:0] c, string req);
      due_q.push_back(cyc + ofs);
      val_q.push_back({p, u, c});
      req_q.push_back(req);
   endtask

   always @(negedge clk) begin
      while (due_q.size() > 0 && due_q[0] <= cyc) begin
         int         d;
         logic [6:0] v;
         string      r;
         d = due_q.pop_front();
         v = val_q.pop_front();
         r = req_q.pop_front();
         if (d < cyc) begin
            compared++;
            mismatched++;
            $display("FAIL %s: got sample at cycle %0d, expected cycle %0d", r, cyc, d);
         end else begin
            check(r, v[6], v[5], v[4:0]);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic drain();
      while (due_q.size() != 0) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #1 supply_ok = 1'b0;
      step(3);
      check("R1 power-up", 1'b1, 1'b1, 5'b00001);
      supply_ok = 1'b1;
      expect_at(RC - 1, 1'b1, 1'b1, 5'b00001, "R2 hold");
      expect_at(RC,     1'b0, 1'b0, 5'b00001, "R2 release");
      drain();

      pin_n = 1'b0;
      expect_at(2, 1'b0, 1'b0, 5'b00001, "R3 sync latency");
      expect_at(3, 1'b1, 1'b1, 5'b00010, "R3 R6 pin reset");
      drain();
      step(2);
      pin_n = 1'b1;
      expect_at(RC + 1, 1'b1, 1'b1, 5'b00010, "R2 pin hold");
      expect_at(RC + 2, 1'b0, 1'b0, 5'b00010, "R2 pin release");
      drain();

      nmi_mode = 1'b1;
      pin_n    = 1'b0;
      expect_at(3, 1'b0, 1'b0, 5'b00010, "R4 nmi pin");
      expect_at(6, 1'b0, 1'b0, 5'b00010, "R4 nmi pin late");
      drain();
      pin_n = 1'b1;
      step(3);
      nmi_mode = 1'b0;
      step(1);

      svs_low = 1'b1;
      expect_at(2, 1'b0, 1'b0, 5'b00010, "R5 svs disabled");
      drain();
      svs_en = 1'b1;
      expect_at(1, 1'b1, 1'b1, 5'b00100, "R5 svs enabled");
      drain();
      svs_low = 1'b0;
      expect_at(RC - 1, 1'b1, 1'b1, 5'b00100, "R2 svs hold");
      expect_at(RC,     1'b0, 1'b0, 5'b00100, "R2 svs release");
      drain();
      svs_en = 1'b0;

      clr = 1'b1;
      expect_at(1, 1'b0, 1'b0, 5'b00000, "R11 clear");
      step(1);
      clr = 1'b0;
      drain();

      wdt = 1'b1;
      expect_at(1,      1'b0, 1'b1, 5'b01000, "R7 wdt puc");
      expect_at(PC,     1'b0, 1'b1, 5'b01000, "R7 wdt stretch");
      expect_at(PC + 1, 1'b0, 1'b0, 5'b01000, "R7 wdt end");
      step(1);
      wdt = 1'b0;
      drain();

      wmode = 1'b1;
      wdt   = 1'b1;
      expect_at(1, 1'b0, 1'b0, 5'b01000, "R7 interval ignored");
      expect_at(3, 1'b0, 1'b0, 5'b01000, "R7 interval ignored later");
      step(1);
      wdt = 1'b0;
      drain();
      wmode = 1'b0;

      flash = 1'b1;
      expect_at(1,      1'b0, 1'b1, 5'b11000, "R8 R10 flash accumulate");
      expect_at(PC + 1, 1'b0, 1'b0, 5'b11000, "R8 flash end");
      step(1);
      flash = 1'b0;
      drain();

      svs_low = 1'b1;
      svs_en  = 1'b1;
      expect_at(1, 1'b1, 1'b1, 5'b00100, "R10 por replaces cause");
      step(2);
      svs_low = 1'b0;
      expect_at(RC, 1'b0, 1'b0, 5'b00100, "R2 release after replace");
      drain();
      svs_en = 1'b0;

      supply_ok = 1'b0;
      #0.2;
      check("R1 brownout immediate", 1'b1, 1'b1, 5'b00001);
      step(2);
      supply_ok = 1'b1;
      expect_at(RC, 1'b0, 1'b0, 5'b00001, "R1 R2 recovery");
      drain();

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: got no end of sequence, expected end within 20000 cycles");
         summary();
         $finish;
      end
   end

endmodule